// File: doc/BRIEF.md
# Programmable Skew Clock Phase Generator

This block is a cycle-accurate digital model of a clock driver with four output pairs, each pair placed at its own phase. It runs from an oversampling clock whose period is one time unit. A tick counter walks through one nominal output period of 16, 26 or 44 ticks, chosen by a three-level range code. A reference waveform (`ref_clk`) is high for the first half of every period.

Each pair takes a two-digit three-level select. The select shifts the pair earlier or later by whole ticks, or switches it to a divided or inverted copy of the zero-skew clock. An edge-select input decides whether the zero-skew clock aligns with the rising or with the falling edge of the reference.

All controls are sampled only at the first tick of a period, so a change never cuts a pulse short in the middle of a cycle. The block suits timing models and emulation of board-level clock trees in which edge placement matters only to whole time units.

Top module: `skew_clock_gen`

## Requirements
- R1: The period is 44 ticks for range code 00, 16 ticks for code 10, and 26 ticks for codes 01 and 11. `ref_clk` is high for ticks 0 to N/2−1 of each period of N ticks and low for the rest.
- R2: Each three-level digit is a 2-bit code: 00 is LOW, 01 is MID, 10 is HIGH, and 11 also reads as MID. Pair p (0..3) uses `pair_sel[4p+3:4p+2]` as the first letter and `pair_sel[4p+1:4p]` as the second.
- R3: Pairs 0 and 1 map the codes LL, LM, LH, ML, MM, MH, HL, HM, HH to skews of −4, −3, −2, −1, 0, +1, +2, +3, +4 ticks. A skew of k makes the pair's rising edge fall at tick (k + zero-skew rise tick) mod N, and the pair stays high for N/2 ticks.
- R4: Pairs 2 and 3 map LM, LH, ML, MM, MH, HL, HM to skews of −6, −4, −2, 0, +2, +4, +6 ticks, with the same placement rule as R3.
- R5: Code LL on pair 2 or pair 3 gives a clock at half the frequency with a 50% duty cycle. It toggles only on zero-skew rising edges.
- R6: Code HH on pair 2 gives a quarter-frequency clock with a 50% duty cycle. It changes only on zero-skew rising edges.
- R7: Code HH on pair 3 gives the zero-skew clock inverted.
- R8: With both digits at MID (01 or 11), a pair follows the zero-skew clock exactly.
- R9: With `align_rise` = 1, the zero-skew clock rises at tick 0 (the reference rising edge). With `align_rise` = 0, it rises at tick N/2 (the reference falling edge).
- R10: Both bits of a pair, `clk_out[2p]` and `clk_out[2p+1]`, are always equal.
- R11: Changes to `pair_sel`, `range_code` and `align_rise` take effect only at the clock edge that starts a new period. At every other edge they are ignored.
- R12: A negative skew places the edge earlier. A skew of −k rises at tick N−k of the period before the zero-skew edge, so every edge stays inside one period.
- R13: While `rst_n` is low, all outputs are low. The first clock edge after release starts a period at tick 0, using the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, one time unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_rise | input | 1 | 1: align to reference rising edge, 0: to falling edge |
| range_code | input | 2 | Three-level period select (00 LOW, 01/11 MID, 10 HIGH) |
| pair_sel | input | 16 | Four two-digit three-level selects, pair p at [4p+3:4p] |
| ref_clk | output | 1 | Reference waveform, high for the first half of each period |
| clk_out | output | 8 | Four output pairs, pair p on bits [2p+1:2p] |

## Verification
Every output is a register loaded from the next-state tick count and configuration, so the value of tick t is visible during the clock cycle that follows the edge that entered tick t. The bench steps its behavioural model once per rising edge and compares all outputs at the falling edge of the same cycle. Control inputs are changed only at falling edges, just after a compare. A control change therefore shows up in the model and in the design at the first edge that wraps the counter, and never earlier; a separate run moves the controls at odd mid-period offsets to show this.

// File: rtl/skew_clk_pkg.sv
package skew_clk_pkg;

  localparam int PAIRS = 4;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    PM_SKEW = 2'd0,
    PM_DIV2 = 2'd1,
    PM_DIV4 = 2'd2,
    PM_INV  = 2'd3
  } pair_mode_e;

  typedef struct packed {
    pair_mode_e         mode;
    logic signed [4:0]  skew;
  } pair_cfg_t;

  // three-level digit: 0 LOW, 1 MID, 2 HIGH; the spare code reads as MID
  function automatic int level_of(input logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int code_index(input logic [3:0] sel);
    return 3 * level_of(sel[3:2]) + level_of(sel[1:0]);
  endfunction

  // coarse pairs step by two ticks and use the end codes for special modes
  function automatic pair_cfg_t decode_pair(input logic [3:0] sel,
                                            input bit coarse,
                                            input bit hh_inverts);
    pair_cfg_t r;
    int idx;
    idx    = code_index(sel);
    r.mode = PM_SKEW;
    r.skew = '0;
    if (!coarse)        r.skew = 5'(idx - 4);
    else if (idx == 0)  r.mode = PM_DIV2;
    else if (idx == 8)  r.mode = hh_inverts ? PM_INV : PM_DIV4;
    else                r.skew = 5'(2 * (idx - 4));
    return r;
  endfunction

  function automatic int cycle_ticks(input logic [1:0] code,
                                     input int lo, input int mid, input int hi);
    case (level_of(code))
      0:       return lo;
      2:       return hi;
      default: return mid;
    endcase
  endfunction

  // rising-edge tick of a pair, folded into [0, len)
  function automatic int phase_offset(input int skew, input int shift, input int len);
    int o;
    o = skew + shift;
    if (o < 0) o = o + len;
    return o;
  endfunction

  function automatic logic wave_at(input int tick, input int off, input int len);
    int d;
    d = tick - off;
    if (d < 0) d = d + len;
    return d < (len / 2);
  endfunction

endpackage

// File: rtl/skew_tick_timer.sv
module skew_tick_timer
  import skew_clk_pkg::*;
#(
  parameter int CYC_LO  = 44,
  parameter int CYC_MID = 26,
  parameter int CYC_HI  = 16,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    range_code,
  output logic          wrap,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] len_q,
  output logic [CW-1:0] cnt_nxt,
  output logic [CW-1:0] len_nxt
);

  logic pend_q;

  always_comb begin
    wrap    = pend_q | (cnt_q == len_q - CW'(1));
    cnt_nxt = wrap ? '0 : cnt_q + CW'(1);
    len_nxt = wrap ? CW'(cycle_ticks(range_code, CYC_LO, CYC_MID, CYC_HI)) : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= CW'(CYC_MID);
    end else begin
      pend_q <= 1'b0;
      cnt_q  <= cnt_nxt;
      len_q  <= len_nxt;
    end
  end

endmodule

// File: rtl/skew_pair_lane.sv
module skew_pair_lane
  import skew_clk_pkg::*;
#(
  parameter int CW         = 6,
  parameter bit COARSE     = 1'b0,
  parameter bit HH_INVERTS = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic [3:0]    sel,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] len_nxt,
  input  logic [CW-1:0] shift_nxt,
  input  logic          zero_edge,
  output logic          lane_q,
  output pair_cfg_t     cfg_q
);

  pair_cfg_t  cfg_nxt;
  logic [1:0] dcnt_q, dcnt_nxt;
  logic       skew_wave, zero_wave, lane_d;

  always_comb begin
    cfg_nxt   = wrap ? decode_pair(sel, COARSE, HH_INVERTS) : cfg_q;
    dcnt_nxt  = zero_edge ? dcnt_q + 2'd1 : dcnt_q;
    skew_wave = wave_at(int'(cnt_nxt),
                        phase_offset(int'($signed(cfg_nxt.skew)), int'(shift_nxt), int'(len_nxt)),
                        int'(len_nxt));
    zero_wave = wave_at(int'(cnt_nxt), int'(shift_nxt), int'(len_nxt));
    case (cfg_nxt.mode)
      PM_DIV2: lane_d = dcnt_nxt[0];
      PM_DIV4: lane_d = dcnt_nxt[1];
      PM_INV:  lane_d = ~zero_wave;
      default: lane_d = skew_wave;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{mode: PM_SKEW, skew: '0};
      dcnt_q <= '0;
      lane_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_nxt;
      dcnt_q <= dcnt_nxt;
      lane_q <= lane_d;
    end
  end

endmodule

// File: rtl/skew_clock_gen.sv
module skew_clock_gen
  import skew_clk_pkg::*;
#(
  parameter int CYC_LO  = 44,
  parameter int CYC_MID = 26,
  parameter int CYC_HI  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   align_rise,
  input  logic [1:0]             range_code,
  input  logic [PAIRS*SEL_W-1:0] pair_sel,
  output logic                   ref_clk,
  output logic [2*PAIRS-1:0]     clk_out
);

  localparam int CW = $clog2(CYC_LO + 1);

  // named events for the checker
  logic                 wrap_evt;
  logic [CW-1:0]        tick_cnt, tick_len;
  logic [CW-1:0]        cnt_nxt, len_nxt, shift_nxt;
  logic                 align_q, align_nxt;
  logic                 zero_edge;
  logic                 zs_q, ref_q;
  logic [PAIRS-1:0]     lane_q;
  pair_cfg_t [PAIRS-1:0] lane_cfg;

  skew_tick_timer #(
    .CYC_LO(CYC_LO), .CYC_MID(CYC_MID), .CYC_HI(CYC_HI), .CW(CW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .range_code(range_code),
    .wrap(wrap_evt), .cnt_q(tick_cnt), .len_q(tick_len),
    .cnt_nxt(cnt_nxt), .len_nxt(len_nxt)
  );

  always_comb begin
    align_nxt = wrap_evt ? align_rise : align_q;
    shift_nxt = align_nxt ? '0 : (len_nxt >> 1);
    zero_edge = (cnt_nxt == shift_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_q <= 1'b1;
      ref_q   <= 1'b0;
      zs_q    <= 1'b0;
    end else begin
      align_q <= align_nxt;
      ref_q   <= (cnt_nxt < (len_nxt >> 1));
      zs_q    <= wave_at(int'(cnt_nxt), int'(shift_nxt), int'(len_nxt));
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_lane
    skew_pair_lane #(
      .CW(CW), .COARSE(p >= 2), .HH_INVERTS(p == 3)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .wrap(wrap_evt),
      .sel(pair_sel[SEL_W*p +: SEL_W]),
      .cnt_nxt(cnt_nxt), .len_nxt(len_nxt), .shift_nxt(shift_nxt),
      .zero_edge(zero_edge),
      .lane_q(lane_q[p]), .cfg_q(lane_cfg[p])
    );
    assign clk_out[2*p +: 2] = {2{lane_q[p]}};
  end

  assign ref_clk = ref_q;

endmodule

// File: rtl/skew_clock_checks.sv
module skew_clock_checks
  import skew_clk_pkg::*;
#(
  parameter int CW = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wrap_evt,
  input logic [CW-1:0]          tick_cnt,
  input logic [CW-1:0]          tick_len,
  input logic                   align_q,
  input logic                   zs_q,
  input logic                   ref_clk,
  input logic [2*PAIRS-1:0]     clk_out,
  input pair_cfg_t [PAIRS-1:0]  lane_cfg
);

  logic [CW-1:0] zpos;
  assign zpos = align_q ? '0 : (tick_len >> 1);

  a_r1_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt < tick_len);

  a_r1_ref_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clk) |-> tick_cnt == '0);

  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(lane_cfg) && $stable(align_q) && $stable(tick_len));

  a_r9_zero_rise_pos: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zs_q) |-> tick_cnt == zpos);

  a_r8_mid_follows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_cfg[0].mode == PM_SKEW && lane_cfg[0].skew == 5'sd0) |-> clk_out[0] == zs_q);

  a_r7_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    lane_cfg[3].mode == PM_INV |-> clk_out[6] != zs_q);

  a_r5_div_toggle_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_cfg[2].mode == PM_DIV2 && $past(lane_cfg[2].mode) == PM_DIV2
     && clk_out[4] != $past(clk_out[4])) |-> tick_cnt == zpos);

endmodule

bind skew_clock_gen skew_clock_checks #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt),
  .tick_cnt(tick_cnt), .tick_len(tick_len), .align_q(align_q),
  .zs_q(zs_q), .ref_clk(ref_clk), .clk_out(clk_out), .lane_cfg(lane_cfg)
);

// File: tb/sim_skew_clock_gen.sv
module sim_skew_clock_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        align_rise = 1'b1;
  logic [1:0]  range_code = 2'b01;
  logic [15:0] pair_sel = 16'h5555;
  logic        ref_clk;
  logic [7:0]  clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string ph = "R8";

  // behavioural model state
  int m_cnt = 0, m_len = 26, m_align = 1, m_dcnt = 0;
  bit m_pend = 1'b1;
  int m_mode [4];
  int m_skew [4];

  skew_clock_gen u0 (
    .clk(clk), .rst_n(rst_n), .align_rise(align_rise), .range_code(range_code),
    .pair_sel(pair_sel), .ref_clk(ref_clk), .clk_out(clk_out)
  );

  always #5 clk = ~clk;

  function automatic int lv(input logic [1:0] c);
    if (c == 2'b10) return 2;
    if (c == 2'b00) return 0;
    return 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] t=%0t got %0d expected %0d", tag, ph, $time, got, exp);
    end
  endtask

  task automatic model_step();
    int h;
    if (m_pend || m_cnt == m_len - 1) begin
      m_cnt   = 0;
      m_len   = (lv(range_code) == 0) ? 44 : (lv(range_code) == 2) ? 16 : 26;
      m_align = align_rise;
      for (int i = 0; i < 4; i++) begin
        int idx;
        idx = 3 * lv(pair_sel[4*i+2 +: 2]) + lv(pair_sel[4*i +: 2]);
        m_mode[i] = 0;
        m_skew[i] = 0;
        if (i < 2) m_skew[i] = idx - 4;
        else if (idx == 0) m_mode[i] = 1;
        else if (idx == 8) m_mode[i] = (i == 2) ? 2 : 3;
        else m_skew[i] = (idx - 4) * 2;
      end
    end else begin
      m_cnt++;
    end
    m_pend = 1'b0;
    h = m_align ? 0 : m_len / 2;
    if (m_cnt == h) m_dcnt = (m_dcnt + 1) % 4;
  endtask

  task automatic compare();
    int h;
    h = m_align ? 0 : m_len / 2;
    check(ref_clk == (m_cnt < m_len / 2), "R1 ref_clk", ref_clk, int'(m_cnt < m_len / 2));
    for (int i = 0; i < 4; i++) begin
      int e;
      string tag;
      int zero;
      zero = ((m_cnt - h + 3 * m_len) % m_len) < m_len / 2;
      case (m_mode[i])
        1: begin e = m_dcnt % 2; tag = "R5 div2"; end
        2: begin e = m_dcnt / 2; tag = "R6 div4"; end
        3: begin e = 1 - zero;   tag = "R7 inverted"; end
        default: begin
          e = ((m_cnt - m_skew[i] - h + 3 * m_len) % m_len) < m_len / 2;
          if (m_skew[i] == 0) tag = "R8 zero skew";
          else if (m_skew[i] < 0) tag = (i < 2) ? "R12 early fine" : "R12 early coarse";
          else tag = (i < 2) ? "R3 fine skew" : "R4 coarse skew";
        end
      endcase
      check(clk_out[2*i] == e[0], $sformatf("%s pair %0d", tag, i), clk_out[2*i], e);
      check(clk_out[2*i+1] == clk_out[2*i], $sformatf("R10 pair %0d twin", i),
            clk_out[2*i+1], clk_out[2*i]);
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      model_step();
      compare();
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R13: outputs low during reset
    check(clk_out == 8'h00, "R13 reset clk_out", clk_out, 0);
    check(ref_clk == 1'b0, "R13 reset ref_clk", ref_clk, 0);
    rst_n = 1'b1;
    ph = "R13/R8 all MID";
    run(100);
    // fine and coarse skews, negative ones included, short period
    ph = "R3/R4/R12 range HIGH";
    range_code = 2'b10;
    pair_sel = {4'b1000, 4'b0001, 4'b1010, 4'b0000};
    run(200);
    // divide by 2, inversion, falling-edge alignment, long period
    ph = "R5/R7/R9 range LOW falling";
    range_code = 2'b00;
    align_rise = 1'b0;
    pair_sel = {4'b1010, 4'b0000, 4'b0100, 4'b0110};
    run(400);
    // spare code 11 as MID, divide by 4
    ph = "R2/R6 code 11";
    range_code = 2'b11;
    align_rise = 1'b1;
    pair_sel = {4'b0000, 4'b1010, 4'b1100, 4'b1101};
    run(400);
    // R11: controls moved at odd points inside a period
    ph = "R11 mid-cycle changes";
    begin
      logic [31:0] s;
      s = 32'h1d3a_77c5;
      for (int k = 0; k < 30; k++) begin
        s = s * 32'd1103515245 + 32'd12345;
        pair_sel   = s[23:8];
        range_code = s[25:24];
        align_rise = s[26];
        run(7 + (k % 5) * 3);
      end
    end
    run(120);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog got no finish expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule